// File: doc/BRIEF.md
# Bit-Field Extract/Insert Execution Unit

This unit executes two immediate bit-field operations of a 32-bit processor. It decodes the instruction word itself and needs only two data operands: the source value A and the current contents of the destination register. The extract operation pulls a field out of A, at an offset and width given in the instruction, and returns it right-aligned with zeros above it. The insert operation takes the low bits of A and writes them into the old destination value at the given offset. Every destination bit outside the field keeps its value.

The two forms encode the field size differently. Extract carries the width itself. Insert carries the position of the field's top bit, so the unit recovers the width as top − offset + 1. Encodings that would put the field outside the word are reported through an illegal flag. Words that are not one of the two operations are ignored. The result, the destination index and the flags are registered, and appear one clock after the input strobe.

Top module: `bfx_unit`

## Requirements
- R1: A strobed word whose value ANDed with 0xFC00C000 equals 0x64004000 is an extract. One that equals 0x64008000 is an insert. Either one raises `out_vld` on the following cycle.
- R2: A strobed word matching neither pattern leaves `out_vld` and `out_ill` low on the next cycle, and `out_res` keeps its previous value.
- R3: `out_rd` carries instruction bits 25:21 of the accepted operation, registered with the result.
- R4: For an extract with offset `sh` = bits 4:0 and width `w` = bits 10:6, where w + sh ≤ 32, `out_res` equals A shifted right by `sh`, with every bit at position w and above cleared.
- R5: An extract with width 0 gives a result of zero and is legal.
- R6: An extract with w + sh > 32 raises `out_ill` and gives a result of zero.
- R7: For an insert with offset `sh` = bits 4:0 and top bit `t` = bits 10:6, where t ≥ sh, result bits sh..t hold A bits 0..t−sh. All other bits equal the old destination value.
- R8: An insert with t = 31 and sh = 0 (width 32) replaces the whole word with A.
- R9: An insert with t < sh raises `out_ill` and passes the old destination value through unchanged.
- R10: Outputs are registered: `out_vld` is high only in the cycle after a strobed, recognised word.
- R11: A synchronous active-high reset clears `out_vld`, `out_ill`, `out_res` and `out_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe |
| in_instr | input | 32 | Instruction word |
| in_opa | input | 32 | Source operand A |
| in_dst | input | 32 | Old destination value |
| out_vld | output | 1 | Result valid |
| out_ill | output | 1 | Illegal field encoding |
| out_rd | output | 5 | Destination register index |
| out_res | output | 32 | Result value |

## Verification
Every result, flag and index is due exactly one clock after the strobe, because a single register stage lies between the inputs and the outputs. The bench drives inputs on the falling edge and drops the strobe on the next falling edge. It checks there, half a period after the capturing edge, so each check reads the cycle that belongs to that stimulus. For ignored words, the same sampling point confirms that valid stayed low and that the result still holds the last expected value.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    localparam int unsigned IW = 32;
    localparam logic [IW-1:0] OPC_MASK = 32'hFC00C000;
    localparam logic [IW-1:0] OPC_EXT  = 32'h64004000;
    localparam logic [IW-1:0] OPC_INS  = 32'h64008000;
    localparam int unsigned RD_LO = 21;
    localparam int unsigned FW_LO = 6;
    localparam int unsigned REGW  = 5;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned SW = $clog2(DW)
) (
    input  logic [IW-1:0]   instr,
    output logic            is_ext,
    output logic            is_ins,
    output logic [REGW-1:0] rd,
    output logic [SW-1:0]   sh,
    output logic [SW:0]     wid,
    output logic            bad
);
    logic [SW-1:0] fld;
    logic [SW:0]   span;

    always_comb begin
        is_ext = (instr & OPC_MASK) == OPC_EXT;
        is_ins = (instr & OPC_MASK) == OPC_INS;
        rd     = instr[RD_LO +: REGW];
        sh     = instr[SW-1:0];
        fld    = instr[FW_LO +: SW];
        span   = {1'b0, fld} + {1'b0, sh};
        if (is_ins) begin
            wid = {1'b0, fld} - {1'b0, sh} + (SW+1)'(1);
            bad = fld < sh;
        end else begin
            wid = {1'b0, fld};
            bad = span > (SW+1)'(DW);
        end
    end
endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
    parameter int unsigned DW = 32,
    localparam int unsigned SW = $clog2(DW)
) (
    input  logic [SW:0]   wid,
    output logic [DW-1:0] mask
);
    logic [DW:0] run;

    always_comb begin
        run  = ({{DW{1'b0}}, 1'b1} << wid) - {{DW{1'b0}}, 1'b1};
        mask = run[DW-1:0];
    end

    always_comb begin
        if (wid <= (SW+1)'(DW))
            p_mask_popcount_r4: assert ($countones(mask) == int'(wid));
    end
endmodule

// File: rtl/bfx_field.sv
module bfx_field #(
    parameter int unsigned DW = 32,
    localparam int unsigned SW = $clog2(DW)
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] dst,
    input  logic [SW-1:0] sh,
    input  logic [SW:0]   wid,
    input  logic          ins,
    output logic [DW-1:0] res
);
    logic [DW-1:0] mask;
    logic [DW-1:0] place;

    bfx_mask #(.DW(DW)) u_mask (.wid(wid), .mask(mask));

    always_comb begin
        place = mask << sh;
        if (ins)
            res = (dst & ~place) | ((opa & mask) << sh);
        else
            res = (opa >> sh) & mask;
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
#(
    parameter int unsigned DW = 32,
    localparam int unsigned SW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [IW-1:0]   in_instr,
    input  logic [DW-1:0]   in_opa,
    input  logic [DW-1:0]   in_dst,
    output logic            out_vld,
    output logic            out_ill,
    output logic [REGW-1:0] out_rd,
    output logic [DW-1:0]   out_res
);
    typedef struct packed {
        logic [DW-1:0]   res;
        logic [REGW-1:0] rd;
        logic            vld;
        logic            ill;
    } st_t;

    st_t st_d, st_q;

    logic            dec_ext, dec_ins, dec_bad;
    logic [REGW-1:0] dec_rd;
    logic [SW-1:0]   dec_sh;
    logic [SW:0]     dec_wid;
    logic [DW-1:0]   fld_res;

    bfx_decode #(.DW(DW)) u_dec (
        .instr(in_instr), .is_ext(dec_ext), .is_ins(dec_ins),
        .rd(dec_rd), .sh(dec_sh), .wid(dec_wid), .bad(dec_bad)
    );

    bfx_field #(.DW(DW)) u_fld (
        .opa(in_opa), .dst(in_dst), .sh(dec_sh), .wid(dec_wid),
        .ins(dec_ins), .res(fld_res)
    );

    always_comb begin
        st_d = st_q;
        st_d.vld = 1'b0;
        st_d.ill = 1'b0;
        if (in_vld && (dec_ext || dec_ins)) begin
            st_d.vld = 1'b1;
            st_d.ill = dec_bad;
            st_d.rd  = dec_rd;
            if (!dec_bad)
                st_d.res = fld_res;
            else if (dec_ins)
                st_d.res = in_dst;
            else
                st_d.res = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_ill = st_q.ill;
    assign out_rd  = st_q.rd;
    assign out_res = st_q.res;

    p_vld_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld));

    p_ill_needs_vld_r9: assert property (@(posedge clk) disable iff (rst)
        out_ill |-> out_vld);

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_res)));

    p_ext_zero_width_r5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ((in_instr & OPC_MASK) == OPC_EXT) && in_instr[10:6] == 5'd0)
        |=> (out_res == '0 && !out_ill));

    p_ins_bad_passthru_r9: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ((in_instr & OPC_MASK) == OPC_INS) && in_instr[10:6] < in_instr[4:0])
        |=> (out_ill && out_res == $past(in_dst)));
endmodule

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [31:0] in_instr, in_opa, in_dst;
    logic        out_vld, out_ill;
    logic [4:0]  out_rd;
    logic [31:0] out_res;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] last_res;

    always #10 clk = ~clk;

    bfx_unit dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_instr(in_instr),
        .in_opa(in_opa), .in_dst(in_dst), .out_vld(out_vld),
        .out_ill(out_ill), .out_rd(out_rd), .out_res(out_res)
    );

    function automatic logic [31:0] mk(input int kind, input logic [4:0] rd,
                                       input logic [4:0] f, input logic [4:0] sh,
                                       input logic [3:0] junk);
        logic [1:0] sel;
        sel = (kind == 0) ? 2'b01 : (kind == 1) ? 2'b10 : junk[1:0];
        return 32'h64000000 | (32'(rd) << 21) | (32'(junk) << 16) |
               (32'(sel) << 14) | (32'(junk[2:0]) << 11) | (32'(f) << 6) |
               (32'(junk[3]) << 5) | 32'(sh);
    endfunction

    function automatic logic [31:0] exp_ext(input logic [31:0] a, input int w, input int sh);
        logic [31:0] r = '0;
        if (w + sh > 32) return '0;
        for (int i = 0; i < w; i++) r[i] = a[i+sh];
        return r;
    endfunction

    function automatic logic [31:0] exp_ins(input logic [31:0] a, input logic [31:0] d,
                                            input int t, input int sh);
        logic [31:0] r = d;
        if (t < sh) return d;
        for (int i = sh; i <= t; i++) r[i] = a[i-sh];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // kind 0 extract, 1 insert, 2 unrecognised
    task automatic run(input int kind, input logic [4:0] rd, input logic [4:0] f,
                       input logic [4:0] sh, input logic [3:0] junk,
                       input logic [31:0] a, input logic [31:0] d, input string req);
        logic [31:0] w;
        logic [31:0] er;
        logic        ei;
        w = mk(kind, rd, f, sh, junk);
        if (kind == 2 && junk[1:0] != 2'b00 && junk[1:0] != 2'b11) w[31] = 1'b1;
        in_instr = w; in_opa = a; in_dst = d; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        if (kind == 2) begin
            chk({req, " R2 vld"}, 32'(out_vld), 32'd0);
            chk({req, " R2 ill"}, 32'(out_ill), 32'd0);
            chk({req, " R2 hold"}, out_res, last_res);
        end else begin
            if (kind == 0) begin
                er = exp_ext(a, int'(f), int'(sh));
                ei = (int'(f) + int'(sh)) > 32;
            end else begin
                er = exp_ins(a, d, int'(f), int'(sh));
                ei = f < sh;
            end
            chk({req, " R1 vld"}, 32'(out_vld), 32'd1);
            chk({req, " ill"}, 32'(out_ill), 32'(ei));
            chk({req, " R3 rd"}, 32'(out_rd), 32'(rd));
            chk({req, " res"}, out_res, er);
            last_res = er;
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd5150));
        rst = 1'b1; in_vld = 1'b0; in_instr = '0; in_opa = '0; in_dst = '0;
        repeat (3) @(negedge clk);
        chk("R11 vld", 32'(out_vld), 32'd0);
        chk("R11 ill", 32'(out_ill), 32'd0);
        chk("R11 res", out_res, 32'd0);
        chk("R11 rd", 32'(out_rd), 32'd0);
        rst = 1'b0;
        last_res = '0;
        @(negedge clk);

        run(0, 5'd3, 5'd8, 5'd4, 4'h0, 32'hDEADBEEF, 32'h0, "R4 nibble");
        run(0, 5'd7, 5'd0, 5'd9, 4'h5, 32'hFFFFFFFF, 32'h0, "R5 zero width");
        run(0, 5'd1, 5'd20, 5'd20, 4'h2, 32'hFFFFFFFF, 32'h0, "R6 overflow");
        run(0, 5'd2, 5'd31, 5'd1, 4'h0, 32'hFFFFFFFF, 32'h0, "R4 edge 31+1");
        run(1, 5'd9, 5'd31, 5'd0, 4'h0, 32'h12345678, 32'hCAFEF00D, "R8 full word");
        run(1, 5'd4, 5'd15, 5'd8, 4'h7, 32'h000000AB, 32'hFFFFFFFF, "R7 byte");
        run(1, 5'd5, 5'd3, 5'd10, 4'h1, 32'hFFFFFFFF, 32'h87654321, "R9 bad order");
        run(1, 5'd6, 5'd31, 5'd31, 4'h0, 32'h00000001, 32'h00000000, "R7 top bit");
        run(2, 5'd8, 5'd4, 5'd4, 4'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2 sel00");
        run(2, 5'd8, 5'd4, 5'd4, 4'h3, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2 sel11");
        run(2, 5'd8, 5'd4, 5'd4, 4'h1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2 opcode");
        @(negedge clk);
        chk("R10 idle vld", 32'(out_vld), 32'd0);

        for (int i = 0; i < 400; i++) begin
            k = int'($urandom_range(0, 9));
            run((k < 4) ? 0 : (k < 8) ? 1 : 2,
                5'($urandom), 5'($urandom), 5'($urandom), 4'($urandom),
                $urandom, $urandom, "random");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule